// File: doc/BRIEF.md
# Wide Template Unfold Engine

This block performs the central step of a graph reduction machine: it turns an application of a function to its arguments into a fresh copy of the function body in heap memory. The body template is fetched from a quad-word program memory four nodes per beat. Each node is rewritten on the fly: argument references become the argument words held on the stack, and application pointers, which are relative to the template start, are moved into the fresh heap region. Every other node is copied as is. The rewritten beat goes straight to a quad-word heap memory with per-lane write enables.

A job is launched with a one-cycle start request that carries the template address and length, the current heap free pointer, the stack pointer and the argument count. The engine first fetches all argument slots in a single cycle, using two quad reads from the stack memory, for eight words at once. It then streams the template. After the first beat it reads one beat and writes one beat every cycle. On completion it pulses a done flag and returns the advanced heap free pointer, the address of the root node (the first word of the copy) and an error flag.

Top module: `unf_engine`

## Requirements
- R1: During and directly after a synchronous active-low reset, busy, done, error and every memory enable are 0, and the returned heap pointer and root address are 0.
- R2: A start request is taken only when the engine is idle. Busy is high from the cycle after acceptance until the done cycle. A request made while busy has no effect on the running job, and its parameters are never used.
- R3: In the first cycle after acceptance, the stack read enable is high and the two quad reads address stack pointer and stack pointer + 4. This yields argument slots 0..7, with lane i of the first read and lane i of the second read holding slots i and 4+i.
- R4: Template beat b (b = 0..ceil(len/4)-1) is read at template address + 4b in cycle 2+b after acceptance. Its rewritten form is written at heap free pointer + 4b one cycle later, so beats flow back to back.
- R5: A node word is {end bit [W-1], tag [W-2:W-4], payload [W-5:0]}. A node with tag 0 (application pointer) has its payload p replaced by heap free pointer + p (modulo 2^ADDR_W), and keeps its tag and end bit.
- R6: A node with tag 1 (argument index) and payload k below the argument count is replaced by stack word (stack pointer + k). Its tag and payload come from the stack word, while the end bit is the template's.
- R7: Nodes with any other tag (2 function, 3 integer, 4 primitive, or unused codes) are written unchanged.
- R8: Heap lane i of beat b is enabled only when 4b+i < len. The enables of a written beat are therefore contiguous from lane 0, and only the final beat can be partial.
- R9: Done is high for exactly one cycle, one cycle after the last beat is written. In that cycle, the returned heap pointer becomes start heap pointer + len and the root address becomes the start heap pointer. Neither changes at any other time.
- R10: An argument-index node whose index is not below the argument count is written unchanged. The error output, updated with done, is 1 for a job that contained such a node and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request |
| tpl_base_i | input | ADDR_W | Template start address |
| tpl_len_i | input | LEN_W | Template length in nodes |
| hp_i | input | ADDR_W | Heap free pointer at start |
| sp_i | input | ADDR_W | Stack pointer to argument slot 0 |
| argc_i | input | ARGC_W | Number of arguments (0..8) |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hp_o | output | ADDR_W | Heap free pointer after the last job |
| root_o | output | ADDR_W | Root node address of the last job |
| err_o | output | 1 | Last job had an out-of-range argument index |
| stk_rd_en_o | output | 1 | Stack read enable (both quads) |
| stk_rd_addr_a_o | output | ADDR_W | Stack quad read address, slots 0..3 |
| stk_rd_addr_b_o | output | ADDR_W | Stack quad read address, slots 4..7 |
| stk_rd_data_a_i | input | 4*WORD_W | Stack quad data, slots 0..3, one cycle after enable |
| stk_rd_data_b_i | input | 4*WORD_W | Stack quad data, slots 4..7, one cycle after enable |
| tpl_rd_en_o | output | 1 | Template read enable |
| tpl_rd_addr_o | output | ADDR_W | Template beat address |
| tpl_rd_data_i | input | 4*WORD_W | Template beat data, lane 0 in low bits, one cycle after enable |
| heap_wr_en_o | output | 1 | Heap write strobe |
| heap_wr_addr_o | output | ADDR_W | Heap beat address |
| heap_wr_be_o | output | 4 | Per-lane heap write enables |
| heap_wr_data_o | output | 4*WORD_W | Rewritten beat, lane 0 in low bits |

## Verification
The hardest situation to reach is the meeting of a partial final beat, slot indices in the upper stack quad, and a start request arriving while a job is still in its argument-fetch and first-beat cycles. From the ports, a dropped request and a wrongly accepted one look alike unless the later writes betray the new parameters. The stimulus therefore raises start with different parameters during the first busy cycles of a seven-node job. It runs a full eight-slot job whose indices point into both stack quads, and a job that mixes in-range and out-of-range indices. The reference model predicts every port in every cycle from the start parameters and its own copies of the memories. A single stray request or lane-enable slip therefore shows up in the cycle where it happens.

// File: rtl/unf_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the unfold engine: lane count, header width,
// node tag codes and sequencer states.
package unf_pkg;
    localparam int LANES = 4;
    localparam int HDR_W = 4;      // end bit + 3-bit tag above the payload

    typedef enum logic [2:0] {
        TAG_APP  = 3'd0,
        TAG_ARG  = 3'd1,
        TAG_FUN  = 3'd2,
        TAG_INT  = 3'd3,
        TAG_PRIM = 3'd4
    } tag_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARG  = 2'd1,
        ST_CAP  = 2'd2,
        ST_RUN  = 2'd3
    } state_e;
endpackage

// File: rtl/unf_ctrl.sv
`timescale 1ns/1ps
// Sequencer of the unfold engine. Latches job parameters on an accepted
// start, issues the stack fetch, streams template beats, tracks the write
// beat and produces the completion results.
// Assumes memories return read data one cycle after the read enable.
module unf_ctrl #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    parameter int ARGC_W = 4,
    localparam int BEAT_W = LEN_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ADDR_W-1:0] hp_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [ARGC_W-1:0] argc_i,
    input  logic              lane_err_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] hp_o,
    output logic [ADDR_W-1:0] root_o,
    output logic              err_o,
    output logic              stk_rd_en_o,
    output logic [ADDR_W-1:0] stk_addr_a_o,
    output logic [ADDR_W-1:0] stk_addr_b_o,
    output logic              tpl_rd_en_o,
    output logic [ADDR_W-1:0] tpl_addr_o,
    output logic              cap_o,
    output logic              wr_vld_o,
    output logic [BEAT_W-1:0] wr_beat_o,
    output logic [ADDR_W-1:0] job_hp_o,
    output logic [LEN_W-1:0]  job_len_o,
    output logic [ARGC_W-1:0] job_argc_o
);
    import unf_pkg::*;

    state_e             state_q;
    logic [ADDR_W-1:0]  base_q, hp_q, sp_q;
    logic [LEN_W-1:0]   len_q;
    logic [ARGC_W-1:0]  argc_q;
    logic [BEAT_W-1:0]  rd_cnt_q, wr_cnt_q, nb;
    logic               wr_vld_q, err_acc_q, done_q, err_q;
    logic [ADDR_W-1:0]  hp_out_q, root_q;
    logic               accept, issue, fin;

    assign accept = (state_q == ST_IDLE) && start_i;
    assign nb     = BEAT_W'(({1'b0, len_q} + (LEN_W+1)'(3)) >> 2);
    assign issue  = ((state_q == ST_CAP) || (state_q == ST_RUN)) && (rd_cnt_q != nb);
    assign fin    = (state_q == ST_RUN) && (rd_cnt_q == nb);

    // Sequencer state: idle -> stack fetch -> capture -> stream -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) state_q <= ST_ARG;
                ST_ARG:  state_q <= ST_CAP;
                ST_CAP:  state_q <= ST_RUN;
                ST_RUN:  if (fin) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Job parameter latch, loaded only on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0; len_q <= '0; hp_q <= '0; sp_q <= '0; argc_q <= '0;
        end else if (accept) begin
            base_q <= base_i; len_q <= len_i; hp_q <= hp_i;
            sp_q <= sp_i; argc_q <= argc_i;
        end
    end

    // Read and write beat counters plus the one-deep write pipeline flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt_q <= '0; wr_cnt_q <= '0; wr_vld_q <= 1'b0;
        end else begin
            wr_vld_q <= issue;
            if (accept)        rd_cnt_q <= '0;
            else if (issue)    rd_cnt_q <= rd_cnt_q + 1'b1;
            if (accept)        wr_cnt_q <= '0;
            else if (wr_vld_q) wr_cnt_q <= wr_cnt_q + 1'b1;
        end
    end

    // Error accumulation across the beats of one job.
    always_ff @(posedge clk) begin
        if (!rst_n)          err_acc_q <= 1'b0;
        else if (accept)     err_acc_q <= 1'b0;
        else if (lane_err_i) err_acc_q <= 1'b1;
    end

    // Completion results, updated once per job together with done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0; hp_out_q <= '0; root_q <= '0; err_q <= 1'b0;
        end else begin
            done_q <= fin;
            if (fin) begin
                hp_out_q <= hp_q + ADDR_W'(len_q);
                root_q   <= hp_q;
                err_q    <= err_acc_q | lane_err_i;
            end
        end
    end

    assign busy_o       = (state_q != ST_IDLE);
    assign done_o       = done_q;
    assign hp_o         = hp_out_q;
    assign root_o       = root_q;
    assign err_o        = err_q;
    assign stk_rd_en_o  = (state_q == ST_ARG);
    assign stk_addr_a_o = sp_q;
    assign stk_addr_b_o = sp_q + ADDR_W'(LANES);
    assign tpl_rd_en_o  = issue;
    assign tpl_addr_o   = base_q + (ADDR_W'(rd_cnt_q) << 2);
    assign cap_o        = (state_q == ST_CAP);
    assign wr_vld_o     = wr_vld_q;
    assign wr_beat_o    = wr_cnt_q;
    assign job_hp_o     = hp_q;
    assign job_len_o    = len_q;
    assign job_argc_o   = argc_q;

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(len_q) && $stable(hp_q) && $stable(base_q))); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R9
    AST_HP_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hp_out_q) |-> done_q); // R9
    AST_STACK_BEFORE_TPL: assert property (@(posedge clk) disable iff (!rst_n)
        stk_rd_en_o |=> !stk_rd_en_o && !wr_vld_q); // R3
endmodule

// File: rtl/unf_argbuf.sv
`timescale 1ns/1ps
// Argument slot buffer. Captures the two stack quads (eight words) in the
// cycle their read data is valid and holds them for the rest of the job.
// Slot i comes from lane i of quad A, slot 4+i from lane i of quad B.
module unf_argbuf #(
    parameter int WORD_W = 20,
    parameter int LANES  = 4,
    localparam int QUAD_W = LANES * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [QUAD_W-1:0] quad_a_i,
    input  logic [QUAD_W-1:0] quad_b_i,
    output logic [2*QUAD_W-1:0] slots_o
);
    logic [2*QUAD_W-1:0] slots_q;

    // Slot register, loaded from both stack ports at once.
    always_ff @(posedge clk) begin
        if (!rst_n)     slots_q <= '0;
        else if (cap_i) slots_q <= {quad_b_i, quad_a_i};
    end

    assign slots_o = slots_q;
endmodule

// File: rtl/unf_lane.sv
`timescale 1ns/1ps
// One lane of the node rewriter. Relocates application pointers, replaces
// in-range argument references with captured stack words (keeping the
// template's end bit) and passes every other node through. Also derives
// the lane's write enable from the beat position and template length.
module unf_lane #(
    parameter int LANE_IDX  = 0,
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 8,
    parameter int ARGC_W    = 4,
    parameter int ARG_SLOTS = 8,
    localparam int WORD_W   = ADDR_W + unf_pkg::HDR_W,
    localparam int BEAT_W   = LEN_W - 1,
    localparam int ARGI_W   = $clog2(ARG_SLOTS)
) (
    input  logic                        vld_i,
    input  logic [BEAT_W-1:0]           beat_i,
    input  logic [LEN_W-1:0]            len_i,
    input  logic [ADDR_W-1:0]           hp_i,
    input  logic [ARGC_W-1:0]           argc_i,
    input  logic [ARG_SLOTS*WORD_W-1:0] slots_i,
    input  logic [WORD_W-1:0]           word_i,
    output logic [WORD_W-1:0]           word_o,
    output logic                        be_o,
    output logic                        err_o
);
    import unf_pkg::*;

    localparam logic [WORD_W-1:0] END_MASK = {1'b1, {(WORD_W-1){1'b0}}};

    logic [LEN_W:0]      pos;
    logic [2:0]          tag;
    logic [ADDR_W-1:0]   pay;
    logic                in_rng;
    logic [WORD_W-1:0]   slot;

    assign pos    = {beat_i, 2'b00} + (LEN_W+1)'(LANE_IDX);
    assign be_o   = vld_i && (pos < {1'b0, len_i});
    assign tag    = word_i[WORD_W-2 -: 3];
    assign pay    = word_i[ADDR_W-1:0];
    assign in_rng = ADDR_W'(argc_i) > pay;
    assign slot   = slots_i[WORD_W*int'(pay[ARGI_W-1:0]) +: WORD_W];

    // Node rewrite selected by tag.
    always_comb begin
        word_o = word_i;
        if (tag == TAG_APP) begin
            word_o = {word_i[WORD_W-1:ADDR_W], hp_i + pay};
        end else if (tag == TAG_ARG && in_rng) begin
            word_o = (slot & ~END_MASK) | (word_i & END_MASK);
        end
    end

    assign err_o = be_o && (tag == TAG_ARG) && !in_rng;
endmodule

// File: rtl/unf_engine.sv
`timescale 1ns/1ps
// Wide template unfold engine. Copies a function body template into fresh
// heap space four nodes per cycle, substituting arguments from the stack
// and relocating application pointers. Assumes all three memories have a
// one-cycle read latency and accept one quad access per port per cycle.
module unf_engine #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    localparam int LANES     = unf_pkg::LANES,
    localparam int WORD_W    = ADDR_W + unf_pkg::HDR_W,
    localparam int ARG_SLOTS = 2 * LANES,
    localparam int ARGC_W    = $clog2(ARG_SLOTS + 1),
    localparam int QUAD_W    = LANES * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] tpl_base_i,
    input  logic [LEN_W-1:0]  tpl_len_i,
    input  logic [ADDR_W-1:0] hp_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [ARGC_W-1:0] argc_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] hp_o,
    output logic [ADDR_W-1:0] root_o,
    output logic              err_o,
    output logic              stk_rd_en_o,
    output logic [ADDR_W-1:0] stk_rd_addr_a_o,
    output logic [ADDR_W-1:0] stk_rd_addr_b_o,
    input  logic [QUAD_W-1:0] stk_rd_data_a_i,
    input  logic [QUAD_W-1:0] stk_rd_data_b_i,
    output logic              tpl_rd_en_o,
    output logic [ADDR_W-1:0] tpl_rd_addr_o,
    input  logic [QUAD_W-1:0] tpl_rd_data_i,
    output logic              heap_wr_en_o,
    output logic [ADDR_W-1:0] heap_wr_addr_o,
    output logic [LANES-1:0]  heap_wr_be_o,
    output logic [QUAD_W-1:0] heap_wr_data_o
);
    localparam int BEAT_W = LEN_W - 1;

    logic                       cap, wr_vld;
    logic [BEAT_W-1:0]          wr_beat;
    logic [ADDR_W-1:0]          job_hp;
    logic [LEN_W-1:0]           job_len;
    logic [ARGC_W-1:0]          job_argc;
    logic [ARG_SLOTS*WORD_W-1:0] slots;
    logic [LANES-1:0]           lane_err;

    unf_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ARGC_W(ARGC_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .base_i(tpl_base_i), .len_i(tpl_len_i), .hp_i(hp_i), .sp_i(sp_i),
        .argc_i(argc_i), .lane_err_i(|lane_err),
        .busy_o(busy_o), .done_o(done_o), .hp_o(hp_o), .root_o(root_o),
        .err_o(err_o), .stk_rd_en_o(stk_rd_en_o),
        .stk_addr_a_o(stk_rd_addr_a_o), .stk_addr_b_o(stk_rd_addr_b_o),
        .tpl_rd_en_o(tpl_rd_en_o), .tpl_addr_o(tpl_rd_addr_o),
        .cap_o(cap), .wr_vld_o(wr_vld), .wr_beat_o(wr_beat),
        .job_hp_o(job_hp), .job_len_o(job_len), .job_argc_o(job_argc)
    );

    unf_argbuf #(.WORD_W(WORD_W), .LANES(LANES)) u_args (
        .clk(clk), .rst_n(rst_n), .cap_i(cap),
        .quad_a_i(stk_rd_data_a_i), .quad_b_i(stk_rd_data_b_i),
        .slots_o(slots)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        unf_lane #(
            .LANE_IDX(l), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
            .ARGC_W(ARGC_W), .ARG_SLOTS(ARG_SLOTS)
        ) u_lane (
            .vld_i(wr_vld), .beat_i(wr_beat), .len_i(job_len),
            .hp_i(job_hp), .argc_i(job_argc), .slots_i(slots),
            .word_i(tpl_rd_data_i[l*WORD_W +: WORD_W]),
            .word_o(heap_wr_data_o[l*WORD_W +: WORD_W]),
            .be_o(heap_wr_be_o[l]), .err_o(lane_err[l])
        );
    end

    assign heap_wr_en_o   = wr_vld;
    assign heap_wr_addr_o = job_hp + (ADDR_W'(wr_beat) << 2);

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        heap_wr_en_o |-> $past(tpl_rd_en_o)); // R4
    AST_LANE0_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        heap_wr_en_o |-> heap_wr_be_o[0]); // R8
    AST_BE_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        heap_wr_en_o |-> (((heap_wr_be_o + 1'b1) & heap_wr_be_o) == '0)); // R8
    AST_NO_BE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !heap_wr_en_o |-> (heap_wr_be_o == '0)); // R8
endmodule

// File: tb/tb_unf_engine.sv
`timescale 1ns/1ps
// Bench: per-cycle behavioural reference model checked at every negedge.
module tb_unf_engine;
    localparam int AW = 16, LW = 8, CW = 4, WW = 20, L = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] base = '0, hp = '0, sp = '0;
    logic [LW-1:0] len = '0;
    logic [CW-1:0] argc = '0;
    logic busy, done, err, stk_en, tpl_en, wr_en;
    logic [AW-1:0] hp_o, root_o, stk_a, stk_b, tpl_addr, wr_addr;
    logic [L*WW-1:0] stk_da, stk_db, tpl_d, wr_d;
    logic [L-1:0] wr_be;

    logic [WW-1:0] tmem [0:255];
    logic [WW-1:0] smem [0:63];

    int nchk = 0, nerr = 0;

    always #2.5 clk = ~clk;

    unf_engine dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .tpl_base_i(base),
        .tpl_len_i(len), .hp_i(hp), .sp_i(sp), .argc_i(argc),
        .busy_o(busy), .done_o(done), .hp_o(hp_o), .root_o(root_o), .err_o(err),
        .stk_rd_en_o(stk_en), .stk_rd_addr_a_o(stk_a), .stk_rd_addr_b_o(stk_b),
        .stk_rd_data_a_i(stk_da), .stk_rd_data_b_i(stk_db),
        .tpl_rd_en_o(tpl_en), .tpl_rd_addr_o(tpl_addr), .tpl_rd_data_i(tpl_d),
        .heap_wr_en_o(wr_en), .heap_wr_addr_o(wr_addr),
        .heap_wr_be_o(wr_be), .heap_wr_data_o(wr_d)
    );

    // Memory models with one cycle of read latency.
    always @(posedge clk) begin
        if (stk_en) for (int l = 0; l < L; l++) begin
            stk_da[l*WW +: WW] <= smem[(int'(stk_a) + l) & 63];
            stk_db[l*WW +: WW] <= smem[(int'(stk_b) + l) & 63];
        end
        if (tpl_en) for (int l = 0; l < L; l++)
            tpl_d[l*WW +: WW] <= tmem[(int'(tpl_addr) + l) & 255];
    end

    task automatic chk(input bit ok, input string req, input longint a, input longint e);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, a, e, $time);
        end
    endtask

    function automatic logic [WW-1:0] mk(input bit e, input int tag, input int pay);
        return {e, 3'(tag), 16'(pay)};
    endfunction

    // Reference model state
    int act = 0, t = 0, D = 0, nb = 0, jb, jl, jh, js, jc;
    bit je;
    logic [AW-1:0] exp_hp = '0, exp_root = '0;
    bit exp_err = 0;

    function automatic logic [WW-1:0] ref_word(input int i, output string req);
        logic [WW-1:0] w;
        int pay, tg;
        w = tmem[(jb + i) & 255];
        tg = int'(w[18:16]);
        pay = int'(w[15:0]);
        if (tg == 0) begin
            req = "R5 app relocate";
            return {w[19:16], 16'(jh + pay)};
        end else if (tg == 1 && pay < jc) begin
            req = "R6 arg substitute";
            return {w[19], smem[(js + pay) & 63][18:0]};
        end else if (tg == 1) begin
            req = "R10 bad arg unchanged";
            return w;
        end
        req = "R7 pass through";
        return w;
    endfunction

    // Per-cycle comparison and model advance.
    always @(negedge clk) begin
        if (!rst_n) begin
            act = 0; t = 0; exp_hp = '0; exp_root = '0; exp_err = 0;
        end else begin
            bit eb, es, et, ew;
            eb = (act != 0) && t < D;
            chk(busy == eb, "R2 busy", busy, eb);
            chk(done == ((act != 0) && t == D), "R9 done", done, (act != 0) && t == D);
            chk(hp_o == exp_hp, "R9 heap pointer", hp_o, exp_hp);
            chk(root_o == exp_root, "R9 root", root_o, exp_root);
            chk(err == exp_err, "R10 error flag", err, exp_err);
            es = (act != 0) && t == 0;
            chk(stk_en == es, "R3 stack enable", stk_en, es);
            if (es) begin
                chk(stk_a == 16'(js), "R3 stack addr a", stk_a, 16'(js));
                chk(stk_b == 16'(js + 4), "R3 stack addr b", stk_b, 16'(js + 4));
            end
            et = (act != 0) && t >= 1 && t <= nb;
            chk(tpl_en == et, "R4 template enable", tpl_en, et);
            if (et) chk(tpl_addr == 16'(jb + 4*(t-1)), "R4 template addr",
                        tpl_addr, 16'(jb + 4*(t-1)));
            ew = (act != 0) && t >= 2 && t <= nb + 1;
            chk(wr_en == ew, "R4 heap enable", wr_en, ew);
            if (ew) begin
                int b;
                b = t - 2;
                chk(wr_addr == 16'(jh + 4*b), "R4 heap addr", wr_addr, 16'(jh + 4*b));
                for (int l = 0; l < L; l++) begin
                    bit ebe;
                    ebe = (4*b + l) < jl;
                    chk(wr_be[l] == ebe, "R8 lane enable", wr_be[l], ebe);
                    if (ebe) begin
                        string rq;
                        logic [WW-1:0] ex;
                        ex = ref_word(4*b + l, rq);
                        chk(wr_d[l*WW +: WW] == ex, rq, wr_d[l*WW +: WW], ex);
                    end
                end
            end else begin
                chk(wr_be == '0, "R8 lane enable idle", wr_be, 0);
            end
            // Advance to the next cycle.
            if ((act == 0 || t == D) && start) begin
                act = 1; t = 0;
                jb = int'(base); jl = int'(len); jh = int'(hp);
                js = int'(sp); jc = int'(argc);
                nb = (jl + 3) / 4;
                D = 2 + ((nb > 0) ? nb : 1);
                je = 0;
                for (int i = 0; i < jl; i++) begin
                    logic [WW-1:0] w;
                    w = tmem[(jb + i) & 255];
                    if (w[18:16] == 3'd1 && int'(w[15:0]) >= jc) je = 1;
                end
            end else if (act != 0) begin
                t++;
                if (t == D) begin
                    exp_hp = 16'(jh + jl); exp_root = 16'(jh); exp_err = je;
                end
                if (t > D) act = 0;
            end
        end
    end

    task automatic run_job(input int b, input int ln, input int h, input int s,
                           input int c, input bit poke);
        @(posedge clk); #1;
        start = 1; base = 16'(b); len = 8'(ln); hp = 16'(h); sp = 16'(s); argc = 4'(c);
        @(posedge clk); #1;
        start = 0;
        if (poke) begin
            // R2: requests during busy with other parameters must be dropped
            start = 1; base = 16'(b + 100); len = 8'(3); hp = 16'(h + 7); argc = 4'(1);
            repeat (2) @(posedge clk);
            #1 start = 0;
        end
        do @(negedge clk); while (!done);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) smem[i] = mk(i % 2, 3, 16'h100 + i);
        for (int i = 0; i < 256; i++) tmem[i] = mk(0, 2, i);
        // Job 1: partial beat, mixed tags
        tmem[0] = mk(0, 0, 5);  tmem[1] = mk(0, 1, 0); tmem[2] = mk(1, 2, 'h33);
        tmem[3] = mk(0, 1, 2);  tmem[4] = mk(1, 3, 'h7777); tmem[5] = mk(0, 4, 9);
        tmem[6] = mk(1, 0, 0);
        // Job 2: full beats, all eight slots
        tmem[16] = mk(0, 1, 7); tmem[17] = mk(1, 1, 4); tmem[18] = mk(0, 0, 3);
        tmem[19] = mk(0, 1, 5); tmem[20] = mk(0, 1, 6); tmem[21] = mk(0, 2, 'h44);
        tmem[22] = mk(1, 1, 1); tmem[23] = mk(1, 0, 7);
        // Job 3: single node, pointer wraps
        tmem[32] = mk(1, 0, 'h20);
        // Job 4: out-of-range indices
        tmem[40] = mk(0, 1, 1); tmem[41] = mk(0, 1, 2); tmem[42] = mk(0, 2, 1);
        tmem[43] = mk(1, 1, 9); tmem[44] = mk(1, 0, 1);
        // Job 5: three beats, unused tag codes, clean
        for (int i = 0; i < 12; i++) tmem[48 + i] = mk(i == 11, (i % 3 == 0) ? 1 : 5 + (i % 3), 0);

        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !err, "R1 reset flags", {busy, done, err}, 0);
        chk(hp_o == 0 && root_o == 0, "R1 reset results", hp_o, 0);
        chk(!stk_en && !tpl_en && !wr_en, "R1 reset enables", {stk_en, tpl_en, wr_en}, 0);
        @(posedge clk); #1 rst_n = 1;

        run_job(0, 7, 100, 10, 3, 1);     // R2 R4 R5 R6 R7 R8 R9
        run_job(16, 8, 200, 20, 8, 0);    // R3 R6 upper stack quad
        run_job(32, 1, 'hFFF0, 0, 0, 0);  // R5 wrap, R8 single lane
        run_job(40, 5, 300, 30, 2, 0);    // R10
        run_job(48, 12, 400, 5, 1, 1);    // R7 R10 cleared, R2
        repeat (5) @(posedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule